// File: doc/BRIEF.md
# Bit-Clock to Word-Clock Ratio Format Detector

This block decides whether an incoming audio link carries a one-bit (density-modulated) stream or a multi-bit PCM stream for an external digital filter. It looks only at the two link clocks. The bit clock and the word clock arrive asynchronously. Both are brought into a faster system clock, and the block counts how many bit-clock rising edges fall between consecutive word-clock rising edges.

The decision is deliberately lopsided. A single word-clock period with too many bit-clock edges moves the block into one-bit mode at once, without waiting for the period to close. Returning to PCM takes two back-to-back periods that each hold a non-zero count at or below the threshold. A period with no bit-clock edges at all is treated as "clock stopped": it carries no information and keeps the mode. When the block leaves one-bit mode, it raises a reset request for a fixed number of word-clock periods so that the downstream datapath can restart cleanly.

Top module: `clk_ratio_fmt_detect`

## Requirements
- R1: The block counts bit-clock rising edges between two consecutive word-clock rising edges. A period with more than THRESH (default 256) edges is "over". A period with 1 to THRESH edges is "under". 256 is under and 257 is over.
- R2: While `det_en` is 1, `mode_o` goes to 1 (one-bit stream) as soon as the running count of the open period exceeds THRESH, without waiting for the next word-clock edge. This includes a word clock held low.
- R3: `mode_o` goes to 0 (extended PCM) at the word-clock rising edge that closes the second of two consecutive under periods. A single under period leaves `mode_o` at 1.
- R4: A period with zero bit-clock edges (bit clock stopped) leaves `mode_o` unchanged and breaks any run of under periods.
- R5: The edge count saturates at THRESH+1. Any number of bit-clock edges without a word-clock edge therefore keeps `mode_o` at 1 and never wraps back to an under count.
- R6: `status_o` equals `mode_o` while `det_en` is 1 and reads 0 while `det_en` is 0.
- R7: While `det_en` is 0, no detection takes place and `mode_o` holds its value. The count and the run of under periods are cleared. After `det_en` returns to 1, counting starts afresh.
- R8: On each change of `mode_o` from 1 to 0, `rst_req_o` rises one system clock later. It stays high until the fourth word-clock rising edge after the change.
- R9: During and after reset, `mode_o`, `status_o` and `rst_req_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, several times faster than the bit clock |
| rst_n | input | 1 | Active-low synchronous system reset |
| det_en | input | 1 | Detection enable |
| bck_i | input | 1 | Bit clock, asynchronous |
| wck_i | input | 1 | Word clock, asynchronous |
| mode_o | output | 1 | Detected format: 1 = one-bit stream, 0 = extended PCM |
| status_o | output | 1 | Readable detection result, forced to 0 while disabled |
| rst_req_o | output | 1 | Datapath reset request after leaving one-bit mode |

## Verification
The hardest states to reach from the ports are the saturated counter and the zero-edge period. Both need the two clocks to stop independently of each other, which a free-running clock pair never does. The bench drives each clock from its own task. It fires more than a thousand bit-clock edges with the word clock parked low, then closes periods that hold no bit-clock edges at all. It also breaks an under-period run with a zero-edge period and straddles the 256/257 boundary, so that each half of the lopsided rule is shown to need exactly its own evidence.

// File: rtl/crfd_pkg.sv
package crfd_pkg;
   typedef enum logic {
      FMT_XPCM   = 1'b0,
      FMT_ONEBIT = 1'b1
   } fmt_e;
endpackage

// File: rtl/crfd_edge_sync.sv
module crfd_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic rise_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("crfd_edge_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] sh_q;
   logic              last_q;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (!rst_n) sh_q[0] <= 1'b0;
            else        sh_q[0] <= async_i;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (!rst_n) sh_q[i] <= 1'b0;
            else        sh_q[i] <= sh_q[i-1];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) last_q <= 1'b0;
      else        last_q <= sh_q[STAGES-1];
   end

   assign rise_o = sh_q[STAGES-1] & ~last_q;

   // a rising-edge pulse never lasts two cycles
   single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o |=> !rise_o);
endmodule

// File: rtl/crfd_edge_count.sv
module crfd_edge_count #(
   parameter int THRESH = 256,
   parameter int CNT_W  = $clog2(THRESH + 2)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic bck_rise,
   input  logic wck_rise,
   output logic over_now_o,
   output logic period_end_o,
   output logic period_over_o,
   output logic period_zero_o
);
   localparam logic [CNT_W-1:0] SAT_V = CNT_W'(THRESH + 1);

   if (THRESH < 1) begin : g_bad_thresh
      $error("crfd_edge_count: THRESH must be at least 1");
   end
   if ((2 ** CNT_W) <= (THRESH + 1)) begin : g_bad_width
      $error("crfd_edge_count: CNT_W too narrow for THRESH");
   end

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_inc;

   always_comb begin
      cnt_inc = cnt_q;
      if (bck_rise && (cnt_q != SAT_V)) cnt_inc = cnt_q + CNT_W'(1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q         <= '0;
         period_end_o  <= 1'b0;
         period_over_o <= 1'b0;
         period_zero_o <= 1'b0;
      end else if (!en) begin
         cnt_q         <= '0;
         period_end_o  <= 1'b0;
         period_over_o <= 1'b0;
         period_zero_o <= 1'b0;
      end else if (wck_rise) begin
         cnt_q         <= '0;
         period_end_o  <= 1'b1;
         period_over_o <= (cnt_inc == SAT_V);
         period_zero_o <= (cnt_inc == '0);
      end else begin
         cnt_q         <= cnt_inc;
         period_end_o  <= 1'b0;
         period_over_o <= 1'b0;
         period_zero_o <= 1'b0;
      end
   end

   assign over_now_o = (cnt_q == SAT_V);

   // R5
   cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && over_now_o && !wck_rise) |=> over_now_o);

   // R7
   cnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (cnt_q == '0) && !period_end_o);
endmodule

// File: rtl/crfd_mode_fsm.sv
module crfd_mode_fsm
   import crfd_pkg::*;
#(
   parameter int CONFIRM = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic over_now,
   input  logic period_end,
   input  logic period_over,
   input  logic period_zero,
   output fmt_e mode_o,
   output logic leave_o
);
   localparam int STRK_W = (CONFIRM < 2) ? 1 : $clog2(CONFIRM);

   if (CONFIRM < 1) begin : g_bad_confirm
      $error("crfd_mode_fsm: CONFIRM must be at least 1");
   end

   logic [STRK_W-1:0] streak_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_o   <= FMT_XPCM;
         streak_q <= '0;
         leave_o  <= 1'b0;
      end else begin
         leave_o <= 1'b0;
         if (!en) begin
            streak_q <= '0;
         end else if (over_now || (period_end && period_over)) begin
            mode_o   <= FMT_ONEBIT;
            streak_q <= '0;
         end else if (period_end) begin
            if (period_zero) begin
               streak_q <= '0;
            end else if (streak_q == STRK_W'(CONFIRM - 1)) begin
               streak_q <= '0;
               mode_o   <= FMT_XPCM;
               if (mode_o == FMT_ONEBIT) leave_o <= 1'b1;
            end else begin
               streak_q <= streak_q + STRK_W'(1);
            end
         end
      end
   end

   // R2
   fast_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && over_now) |=> (mode_o == FMT_ONEBIT));

   // R3
   slow_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == FMT_XPCM) && $past(mode_o == FMT_ONEBIT) |-> $past(period_end));

   // R7
   hold_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> $stable(mode_o));

   // R4
   zero_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && period_end && period_zero && !over_now) |=> $stable(mode_o));
endmodule

// File: rtl/crfd_rst_req.sv
module crfd_rst_req #(
   parameter int PERIODS = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic leave_i,
   input  logic wck_rise,
   output logic req_o
);
   localparam int PW = $clog2(PERIODS) + 1;

   if (PERIODS < 1) begin : g_bad_periods
      $error("crfd_rst_req: PERIODS must be at least 1");
   end

   logic [PW-1:0] per_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_o <= 1'b0;
         per_q <= '0;
      end else if (leave_i) begin
         req_o <= 1'b1;
         per_q <= '0;
      end else if (req_o && wck_rise) begin
         if (per_q == PW'(PERIODS - 1)) begin
            req_o <= 1'b0;
            per_q <= '0;
         end else begin
            per_q <= per_q + PW'(1);
         end
      end
   end

   // R8
   req_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      leave_i |=> req_o);

   // R8
   req_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!leave_i && !wck_rise) |=> $stable(req_o));
endmodule

// File: rtl/clk_ratio_fmt_detect.sv
module clk_ratio_fmt_detect
   import crfd_pkg::*;
#(
   parameter int THRESH      = 256,
   parameter int CONFIRM     = 2,
   parameter int RST_PERIODS = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic det_en,
   input  logic bck_i,
   input  logic wck_i,
   output logic mode_o,
   output logic status_o,
   output logic rst_req_o
);
   localparam int CNT_W = $clog2(THRESH + 2);

   logic bck_rise, wck_rise;
   logic over_now, period_end, period_over, period_zero;
   logic leave;
   fmt_e mode;

   crfd_edge_sync #(.STAGES(SYNC_STAGES)) u_bck_sync (
      .clk(clk), .rst_n(rst_n), .async_i(bck_i), .rise_o(bck_rise));

   crfd_edge_sync #(.STAGES(SYNC_STAGES)) u_wck_sync (
      .clk(clk), .rst_n(rst_n), .async_i(wck_i), .rise_o(wck_rise));

   crfd_edge_count #(.THRESH(THRESH), .CNT_W(CNT_W)) u_count (
      .clk(clk), .rst_n(rst_n), .en(det_en),
      .bck_rise(bck_rise), .wck_rise(wck_rise),
      .over_now_o(over_now), .period_end_o(period_end),
      .period_over_o(period_over), .period_zero_o(period_zero));

   crfd_mode_fsm #(.CONFIRM(CONFIRM)) u_fsm (
      .clk(clk), .rst_n(rst_n), .en(det_en),
      .over_now(over_now), .period_end(period_end),
      .period_over(period_over), .period_zero(period_zero),
      .mode_o(mode), .leave_o(leave));

   crfd_rst_req #(.PERIODS(RST_PERIODS)) u_rreq (
      .clk(clk), .rst_n(rst_n), .leave_i(leave),
      .wck_rise(wck_rise), .req_o(rst_req_o));

   assign mode_o   = (mode == FMT_ONEBIT);
   assign status_o = det_en & mode_o;

   // R9
   reset_idle_chk: assert property (@(posedge clk)
      !rst_n |=> !mode_o && !rst_req_o);
endmodule

// File: tb/clk_ratio_fmt_detect_bench.sv
module clk_ratio_fmt_detect_bench;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic det_en = 1'b0;
   logic bck_i = 1'b0;
   logic wck_i = 1'b0;
   logic mode_o, status_o, rst_req_o;

   int checks = 0;
   int errors = 0;
   int cyc = 0;

   always #2 clk = ~clk;

   clk_ratio_fmt_detect u_clk_ratio_fmt_detect (
      .clk(clk), .rst_n(rst_n), .det_en(det_en), .bck_i(bck_i), .wck_i(wck_i),
      .mode_o(mode_o), .status_o(status_o), .rst_req_o(rst_req_o));

   // edges per period, expected mode and expected reset request after the call
   localparam int NV = 11;
   localparam int VEC_EDGES [NV] = '{100, 257, 100, 100, 256, 300, 256,   0, 256, 256, 10};
   localparam int VEC_MODE  [NV] = '{  0,   1,   1,   1,   0,   1,   1,   1,   1,   1,  0};
   localparam int VEC_REQ   [NV] = '{  0,   0,   0,   0,   1,   1,   1,   1,   0,   0,  1};

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic bck_pulses(input int n);
      for (int k = 0; k < n; k++) begin
         bck_i = 1'b1; #8;
         bck_i = 1'b0; #8;
      end
   endtask

   // word-clock rise closes the previous period, then n bit-clock edges
   task automatic period(input int n);
      wck_i = 1'b1; #16;
      wck_i = 1'b0;
      bck_pulses(n);
      #60;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      #1;
      #40;
      // R9: reset state
      chk("R9 mode in reset", mode_o, 0);
      chk("R9 status in reset", status_o, 0);
      chk("R9 req in reset", rst_req_o, 0);
      rst_n = 1'b1;
      #40;
      chk("R9 req after reset", rst_req_o, 0);
      det_en = 1'b1;
      #20;

      // table walk: R1 boundary 256/257, R2 fast entry, R3 two-period exit, R4 zero period
      for (int i = 0; i < NV; i++) begin
         period(VEC_EDGES[i]);
         chk($sformatf("R1/R2/R3/R4 mode row %0d", i), mode_o, VEC_MODE[i]);
         chk($sformatf("R6 status row %0d", i), status_o, VEC_MODE[i]);
         chk($sformatf("R8 req row %0d", i), rst_req_o, VEC_REQ[i]);
      end

      // R2: word clock parked low, count crosses threshold
      bck_pulses(320);
      #40;
      chk("R2 entry with word clock low", mode_o, 1);
      // R5: far beyond saturation, still one-bit
      bck_pulses(1000);
      #40;
      chk("R5 saturated count", mode_o, 1);
      period(0);
      chk("R5 saturated period closed", mode_o, 1);
      // R4: bit clock stopped for several periods
      period(0);
      period(0);
      period(0);
      chk("R4 stopped bit clock holds mode", mode_o, 1);
      // R4: zero period breaks an under run
      period(50);
      period(0);
      period(50);
      chk("R4 run broken by zero period", mode_o, 1);

      // R7/R6: disable
      det_en = 1'b0;
      #40;
      chk("R6 status when disabled", status_o, 0);
      chk("R7 mode held when disabled", mode_o, 1);
      period(50);
      period(50);
      period(50);
      chk("R7 no detection while disabled", mode_o, 1);
      det_en = 1'b1;
      #20;
      chk("R6 status re-enabled", status_o, 1);
      period(50);
      chk("R7 partial period after enable ignored", mode_o, 1);
      period(50);
      chk("R3 one under period not enough", mode_o, 1);
      period(50);
      chk("R3 second under period exits", mode_o, 0);
      chk("R8 req after exit", rst_req_o, 1);
      period(0);
      period(0);
      period(0);
      chk("R8 req held for three periods", rst_req_o, 1);
      period(0);
      chk("R8 req drops at fourth edge", rst_req_o, 0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule